// File: doc/BRIEF.md
# SDRAM Read Command Sequencer

This block sits between a simple read-request port and the command pins of an SDRAM device. Each request names a bank, a row, a column, a beat count and whether it continues the previous access. The sequencer keeps a table of the row that is currently open in every bank. From that table it decides whether the request can be served by a READ alone, needs an ACTIVATE first, or must close a different row with PRECHARGE before activating the wanted one.

Between the commands it places programmable idle gaps for row precharge and row-to-column delay. It then counts out the CAS latency. The device always bursts eight beats. When fewer beats are asked for, the sequencer issues a burst-terminate command at the point that leaves exactly the wanted number of beats. A data-valid strobe marks the cycles in which the device drives the requested beats. The host keeps the configuration inputs stable while a request is in flight.

Top module: `sdram_rd_seq`

## Requirements
- R1: During and after synchronous reset, every bank is marked closed, `req_ready` is 1, `cmd` is NOP and `rd_valid` is 0.
- R2: A request with `req_seq`=0 whose bank has `req_row` open issues READ in the first cycle after acceptance, with `cmd_bank` equal to the bank and `cmd_addr` equal to the column zero-extended.
- R3: A request to a bank with no open row issues ACTIVATE (`cmd_addr` = row) in the first cycle after acceptance, then `cfg_trcd` NOP cycles, then READ.
- R4: A request to a bank holding a different open row issues PRECHARGE for that bank with `cmd_addr` all zero, then `cfg_trp` NOP cycles, then ACTIVATE, then `cfg_trcd` NOP cycles, then READ. The open rows of the other banks are kept.
- R5: The first `rd_valid` beat comes CL cycles after the READ cycle, where CL is 2 for `cfg_cas3`=0 and 3 for `cfg_cas3`=1.
- R6: `rd_valid` is high for exactly n consecutive cycles per request, where n is `req_beats`, and a `req_beats` of 0 or above 8 counts as 8.
- R7: For n below 8, BURST STOP is issued exactly n cycles after READ. For n equal to 8, no BURST STOP is issued.
- R8: A request with `req_seq`=1, made after at least one earlier request since reset, issues READ in the first cycle after acceptance to the previous request's bank, ignoring `req_bank` and `req_row`. With no earlier request, it is handled as if `req_seq` were 0.
- R9: Command codes on `cmd` are {RAS#,CAS#,WE#}: ACTIVATE 011, READ 101, PRECHARGE 010, BURST STOP 110, NOP 111. Every cycle without one of the first four carries NOP.
- R10: `req_ready` is high only while idle, and returns high CL+n cycles after the READ cycle. `req_valid` is ignored while `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trp | input | 4 | NOP cycles between PRECHARGE and ACTIVATE |
| cfg_trcd | input | 4 | NOP cycles between ACTIVATE and READ |
| cfg_cas3 | input | 1 | CAS latency select: 0 gives 2 cycles, 1 gives 3 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Start column |
| req_beats | input | 4 | Beats wanted, 1 to 8 (0 or above 8 means 8) |
| req_seq | input | 1 | Continue in the previous access's open page |
| cmd | output | 3 | Command as {RAS#,CAS#,WE#} |
| cmd_bank | output | 2 | Bank address for the command |
| cmd_addr | output | 13 | Row or column address for the command |
| rd_valid | output | 1 | Requested read beat on the data bus |

## Verification
Burst termination and data capture overlap. Whenever n is at least the CAS latency and below 8, BURST STOP goes out in a cycle in which `rd_valid` is already high for an earlier beat of the same read. Directed and random requests with beat counts from 1 to 9 and both latencies cause this overlap. The bench compares the command and the strobe against a cycle-by-cycle expected trace, so the strobe must stop exactly after n beats while the terminate command appears at its own cycle. Busy-time request noise and same-page continuations are mixed in to show that neither disturbs the trace.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int BANK_W    = 2;
    localparam int ROW_W     = 13;
    localparam int COL_W     = 10;
    localparam int BEAT_W    = 4;
    localparam int BURST_LEN = 8;
    localparam int NUM_BANKS = 1 << BANK_W;

    // {RAS#, CAS#, WE#}
    typedef enum logic [2:0] {
        CMD_ACT = 3'b011,
        CMD_PRE = 3'b010,
        CMD_RD  = 3'b101,
        CMD_BST = 3'b110,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_TRP, S_ACT, S_TRCD, S_RD, S_BURST
    } seq_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [BEAT_W-1:0] beats;
    } rd_req_t;

    function automatic logic [BEAT_W-1:0] clamp_beats(input logic [BEAT_W-1:0] b);
        if (b == '0 || int'(b) > BURST_LEN)
            return BEAT_W'(BURST_LEN);
        return b;
    endfunction

    function automatic logic [1:0] cas_cycles(input logic cas3);
        return cas3 ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/srs_row_table.sv
module srs_row_table import srs_pkg::*; #(
    parameter int BW = BANK_W,
    parameter int RW = ROW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] lk_bank,
    input  logic [RW-1:0] lk_row,
    output logic          lk_open,
    output logic          lk_hit,
    input  logic          act_en,
    input  logic [BW-1:0] act_bank,
    input  logic [RW-1:0] act_row,
    input  logic          pre_en,
    input  logic [BW-1:0] pre_bank
);
    localparam int NB = 1 << BW;

    logic          open_q [NB];
    logic [RW-1:0] row_q  [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[g] <= 1'b0;
                row_q[g]  <= '0;
            end else if (act_en && act_bank == BW'(g)) begin
                open_q[g] <= 1'b1;
                row_q[g]  <= act_row;
            end else if (pre_en && pre_bank == BW'(g)) begin
                open_q[g] <= 1'b0;
            end
        end
    end

    assign lk_open = open_q[lk_bank];
    assign lk_hit  = open_q[lk_bank] && (row_q[lk_bank] == lk_row);

    // R3: activation only ever targets a closed bank
    a_r3_act_on_closed: assert property (@(posedge clk) disable iff (rst)
        act_en |-> !open_q[act_bank]);

    // R4: precharge only ever targets an open bank
    a_r4_pre_on_open: assert property (@(posedge clk) disable iff (rst)
        pre_en |-> open_q[pre_bank]);

endmodule

// File: rtl/srs_burst_timer.sv
module srs_burst_timer import srs_pkg::*; #(
    parameter int CW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BEAT_W-1:0] beats_i,
    input  logic              cas3_i,
    output logic              bst_o,
    output logic              valid_o,
    output logic              done_o
);
    logic          active;
    logic [CW-1:0] cyc, n_q, cl_q, last;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cyc    <= '0;
            n_q    <= '0;
            cl_q   <= '0;
        end else if (start) begin
            active <= 1'b1;
            cyc    <= CW'(1);
            n_q    <= CW'(beats_i);
            cl_q   <= CW'(cas_cycles(cas3_i));
        end else if (active) begin
            if (done_o) active <= 1'b0;
            cyc <= cyc + 1'b1;
        end
    end

    assign last    = cl_q + n_q - 1'b1;
    assign valid_o = active && cyc >= cl_q && cyc <= last;
    assign bst_o   = active && cyc == n_q && n_q < CW'(BURST_LEN);
    assign done_o  = active && cyc == last;

    // checker: beats flagged since the READ
    logic [CW-1:0] vcnt;
    always_ff @(posedge clk) begin
        if (rst || start) vcnt <= '0;
        else if (valid_o) vcnt <= vcnt + 1'b1;
    end

    // R6: the last valid beat is the n-th one
    a_r6_beat_count: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (vcnt + 1'b1) == n_q);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq import srs_pkg::*; #(
    parameter int TW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TW-1:0]     cfg_trp,
    input  logic [TW-1:0]     cfg_trcd,
    input  logic              cfg_cas3,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              req_seq,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic              rd_valid
);
    seq_state_e        state;
    rd_req_t           cur;
    logic [TW-1:0]     wcnt;
    logic [BANK_W-1:0] last_bank;
    logic [ROW_W-1:0]  last_row;
    logic              have_last;

    logic              accept, seq_use, lk_open, lk_hit;
    logic [BANK_W-1:0] eff_bank;
    logic [ROW_W-1:0]  eff_row;
    logic              bst, done;
    cmd_e              cmd_c;

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign seq_use   = req_seq && have_last;
    assign eff_bank  = seq_use ? last_bank : req_bank;
    assign eff_row   = seq_use ? last_row  : req_row;

    srs_row_table #(.BW(BANK_W), .RW(ROW_W)) i_rows (
        .clk      (clk),
        .rst      (rst),
        .lk_bank  (eff_bank),
        .lk_row   (eff_row),
        .lk_open  (lk_open),
        .lk_hit   (lk_hit),
        .act_en   (state == S_ACT),
        .act_bank (cur.bank),
        .act_row  (cur.row),
        .pre_en   (state == S_PRE),
        .pre_bank (cur.bank)
    );

    srs_burst_timer #(.CW(5)) i_burst (
        .clk     (clk),
        .rst     (rst),
        .start   (state == S_RD),
        .beats_i (cur.beats),
        .cas3_i  (cfg_cas3),
        .bst_o   (bst),
        .valid_o (rd_valid),
        .done_o  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur       <= '0;
            wcnt      <= '0;
            last_bank <= '0;
            last_row  <= '0;
            have_last <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    cur       <= '{bank: eff_bank, row: eff_row, col: req_col,
                                   beats: clamp_beats(req_beats)};
                    last_bank <= eff_bank;
                    last_row  <= eff_row;
                    have_last <= 1'b1;
                    if (seq_use || lk_hit) state <= S_RD;
                    else if (!lk_open)     state <= S_ACT;
                    else                   state <= S_PRE;
                end
                S_PRE: begin
                    wcnt  <= cfg_trp;
                    state <= (cfg_trp == '0) ? S_ACT : S_TRP;
                end
                S_TRP: begin
                    wcnt <= wcnt - 1'b1;
                    if (wcnt == TW'(1)) state <= S_ACT;
                end
                S_ACT: begin
                    wcnt  <= cfg_trcd;
                    state <= (cfg_trcd == '0) ? S_RD : S_TRCD;
                end
                S_TRCD: begin
                    wcnt <= wcnt - 1'b1;
                    if (wcnt == TW'(1)) state <= S_RD;
                end
                S_RD:    state <= S_BURST;
                S_BURST: if (done) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_c    = CMD_NOP;
        cmd_addr = '0;
        unique case (state)
            S_PRE:   cmd_c = CMD_PRE;
            S_ACT: begin
                cmd_c    = CMD_ACT;
                cmd_addr = cur.row;
            end
            S_RD: begin
                cmd_c    = CMD_RD;
                cmd_addr = ROW_W'(cur.col);
            end
            S_BURST: if (bst) cmd_c = CMD_BST;
            default: cmd_c = CMD_NOP;
        endcase
    end

    assign cmd      = cmd_c;
    assign cmd_bank = cur.bank;

    // checker: cycles since the last PRECHARGE
    logic [TW:0] pre_gap;
    logic        pre_seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_gap  <= '0;
            pre_seen <= 1'b0;
        end else if (cmd_c == CMD_PRE) begin
            pre_gap  <= (TW+1)'(1);
            pre_seen <= 1'b1;
        end else begin
            if (pre_gap != '1) pre_gap <= pre_gap + 1'b1;
            if (cmd_c == CMD_ACT) pre_seen <= 1'b0;
        end
    end

    // R4: ACTIVATE after PRECHARGE keeps the programmed gap
    a_r4_trp_gap: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'b011 && pre_seen) |-> pre_gap == ({1'b0, cfg_trp} + 1'b1));

    // R2: an open-page hit reads on the very next cycle
    a_r2_hit_reads: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !seq_use && lk_hit) |=> cmd == 3'b101);

    // R8: a continuation reads on the very next cycle
    a_r8_seq_reads: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && seq_use) |=> cmd == 3'b101);

    // R10: no data beat while the sequencer takes requests
    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !rd_valid);

endmodule

// File: tb/test_sdram_rd_seq.sv
module test_sdram_rd_seq;

    localparam logic [2:0] C_NOP = 3'b111;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_BST = 3'b110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_trp = '0, cfg_trcd = '0;
    logic        cfg_cas3 = 1'b0;
    logic        req_valid = 1'b0, req_seq = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [3:0]  req_beats = '0;
    logic [2:0]  cmd;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model of open rows
    bit          m_open [4];
    logic [12:0] m_row  [4];
    bit          m_have;
    logic [1:0]  m_lbank;
    logic [12:0] m_lrow;

    sdram_rd_seq i_sdram_rd_seq (
        .clk(clk), .rst(rst), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
        .cfg_cas3(cfg_cas3), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_beats(req_beats), .req_seq(req_seq), .cmd(cmd),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .rd_valid(rd_valid)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int eff_beats(input logic [3:0] b);
        return (b == 0 || b > 8) ? 8 : int'(b);
    endfunction

    function automatic string cmd_tag(input logic [2:0] c, input bit seq);
        case (c)
            C_PRE:   return "R4";
            C_ACT:   return "R3";
            C_RD:    return seq ? "R8" : "R2";
            C_BST:   return "R7";
            default: return "R9";
        endcase
    endfunction

    // Called at a negedge with the DUT idle; returns at a negedge, idle again.
    task automatic run_req(input logic [1:0] b, input logic [12:0] row,
                           input logic [9:0] col, input logic [3:0] beats,
                           input bit seq, input logic [3:0] trp,
                           input logic [3:0] trcd, input bit cas3, input bit junk);
        int kind, n, cl, r, act_i, end_i;
        logic [1:0]  eb;
        logic [12:0] er;
        bit seq_use;
        cfg_trp = trp; cfg_trcd = trcd; cfg_cas3 = cas3;
        req_bank = b; req_row = row; req_col = col; req_beats = beats;
        req_seq = seq; req_valid = 1'b1;
        seq_use = seq && m_have;
        eb = seq_use ? m_lbank : b;
        er = seq_use ? m_lrow : row;
        if (seq_use || (m_open[eb] && m_row[eb] == er)) kind = 0;
        else if (!m_open[eb]) kind = 1;
        else kind = 2;
        n = eff_beats(beats);
        cl = cas3 ? 3 : 2;
        act_i = (kind == 1) ? 0 : 1 + int'(trp);
        r = (kind == 0) ? 0 : (kind == 1) ? 1 + int'(trcd) : 2 + int'(trp) + int'(trcd);
        end_i = r + cl + n;
        m_open[eb] = 1'b1; m_row[eb] = er;
        m_have = 1'b1; m_lbank = eb; m_lrow = er;
        @(posedge clk);
        for (int idx = 0; idx <= end_i; idx++) begin
            logic [2:0]  ecmd;
            logic [12:0] eaddr;
            bit evalid;
            @(negedge clk);
            req_valid = junk && idx < end_i;
            if (junk) begin
                req_bank = 2'($urandom); req_row = 13'($urandom);
                req_col = 10'($urandom); req_beats = 4'($urandom);
                req_seq = 1'($urandom);
            end
            ecmd = C_NOP; eaddr = '0;
            if (kind == 2 && idx == 0) ecmd = C_PRE;
            if (kind != 0 && idx == act_i) begin ecmd = C_ACT; eaddr = er; end
            if (idx == r) begin ecmd = C_RD; eaddr = 13'(col); end
            if (n < 8 && idx == r + n) ecmd = C_BST;
            evalid = idx >= r + cl && idx < r + cl + n;
            chk(cmd == ecmd, cmd_tag(ecmd, seq_use), "cmd", cmd, ecmd);
            if (ecmd == C_PRE || ecmd == C_ACT || ecmd == C_RD) begin
                chk(cmd_bank == eb, cmd_tag(ecmd, seq_use), "cmd_bank", cmd_bank, eb);
                chk(cmd_addr == eaddr, cmd_tag(ecmd, seq_use), "cmd_addr", cmd_addr, eaddr);
            end
            chk(rd_valid == evalid, (idx == r + cl) ? "R5" : "R6", "rd_valid",
                rd_valid, evalid);
            chk(req_ready == (idx == end_i), "R10", "req_ready", req_ready, idx == end_i);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = '0; end
        m_have = 0; m_lbank = '0; m_lrow = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(cmd == C_NOP, "R1", "cmd in reset", cmd, C_NOP);
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(cmd == C_NOP, "R1", "cmd after reset", cmd, C_NOP);

        // R8: continuation with no history behaves as a fresh access (R3 path)
        run_req(2'd0, 13'd5, 10'd3, 4'd2, 1'b1, 4'd1, 4'd1, 1'b0, 1'b0);
        // R3, R7: closed bank, short burst
        run_req(2'd1, 13'd100, 10'd17, 4'd4, 1'b0, 4'd2, 4'd2, 1'b0, 1'b0);
        // R2, R5, R7: hit, single beat, CL3
        run_req(2'd1, 13'd100, 10'd40, 4'd1, 1'b0, 4'd2, 4'd2, 1'b1, 1'b0);
        // R6: beat count 0 means 8, no BST
        run_req(2'd2, 13'd7, 10'd8, 4'd0, 1'b0, 4'd3, 4'd1, 1'b1, 1'b0);
        // R4: row conflict with zero gaps
        run_req(2'd1, 13'd200, 10'd1, 4'd3, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0);
        // R4: other bank kept open
        run_req(2'd2, 13'd7, 10'd9, 4'd9, 1'b0, 4'd2, 4'd2, 1'b0, 1'b0);
        // R8: continuation ignores bank and row fields
        run_req(2'd3, 13'd999, 10'd12, 4'd5, 1'b1, 4'd2, 4'd2, 1'b1, 1'b0);
        // R10: request noise while busy
        run_req(2'd0, 13'd77, 10'd5, 4'd6, 1'b0, 4'd4, 4'd3, 1'b1, 1'b1);

        for (int k = 0; k < 300; k++) begin
            run_req(2'($urandom), 13'($urandom % 3), 10'($urandom),
                    4'($urandom % 10), ($urandom % 4) == 0,
                    4'($urandom % 4), 4'($urandom % 4), 1'($urandom),
                    ($urandom % 3) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule